// File: doc/BRIEF.md
# Four-Subcarrier Group Partial Deinterleaver

This block reorders one subframe of demodulated samples ahead of a bit-processing engine. Software or an upstream engine first loads an internal buffer in symbol-major order: every used subcarrier of symbol 0, then every used subcarrier of symbol 1, and so on. A start pulse then latches the subcarrier count and the symbol count. The block streams the buffer back out in a grouped order. Subcarriers are taken four at a time. Inside one group, the subcarrier offset (0..3) changes on every sample, and the symbol index moves forward after every fourth sample. A group is finished once it has covered every symbol, and only then does the next group of four begin.

The output is a valid/ready stream. The buffer is a synchronous single-port RAM with one cycle of read latency. A two-entry skid buffer absorbs that latency, so reads stop cleanly under backpressure and the stream runs at one sample per cycle whenever the sink is always ready. A one-cycle done pulse marks the end of the subframe. A configuration error flag rejects counts the block cannot handle.

Top module: `grp4_deinterleaver`

## Requirements
- R1: For a subcarrier count C and a symbol count S, output sample number k = g*4*S + i (g the group, i from 0 to 4*S-1) carries the buffer word at address (i/4)*C + g*4 + (i mod 4). Samples are emitted in increasing k.
- R2: Each accepted start produces exactly C*S output handshakes, followed by a done pulse.
- R3: While outValid is high and outReady is low, outValid stays high and outData keeps its value on the next cycle.
- R4: Under any outReady pattern, no sample is lost, repeated or reordered.
- R5: done is high for exactly one cycle. That cycle is the one right after the clock edge that accepts the last sample. During it, busy and outValid are low.
- R6: A start with C equal to 0, C not a multiple of 4, C above MAX_SC, S equal to 0 or S above MAX_SYM sets cfgErr. In that case busy stays low and no sample and no done follow. The next start with legal counts clears cfgErr.
- R7: A start pulse while busy is high has no effect on the ongoing output sequence.
- R8: A buffer write (wrEn) while busy is high does not change the buffer contents.
- R9: After reset, outValid, busy, done and cfgErr are low. While busy is low, outValid is low.
- R10: With outReady held high, the samples of one run are accepted on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Buffer write strobe, honoured only when idle |
| wrAddr | input | AW (11) | Buffer write address, symbol*C + subcarrier |
| wrData | input | DW (16) | Buffer write data |
| cfgNumSc | input | SCW (7) | Used subcarrier count C, sampled on start |
| cfgNumSym | input | SYMW (4) | Symbol count S, sampled on start |
| start | input | 1 | Start pulse, accepted only when idle |
| busy | output | 1 | High from an accepted start until done |
| done | output | 1 | One-cycle end-of-subframe pulse |
| cfgErr | output | 1 | Last start carried illegal counts |
| outValid | output | 1 | Output sample valid |
| outReady | input | 1 | Sink ready |
| outData | output | DW (16) | Output sample |

## Verification
The properties assume that start arrives as a pulse, that buffer writes use addresses below C*S, and that outReady may change freely on any cycle. The bench drives only in-range write addresses. It loads the buffer only while the block is idle, except for one deliberate write during a run. It varies outReady between always-high, alternating and random patterns, so that the stall and throughput properties are exercised. Illegal counts are sent only as whole start pulses, and a legal run always follows to confirm that the error flag clears.

// File: rtl/gdi_pkg.sv
package gdi_pkg;

  // Strobes sent from the sequencer to the storage datapath
  typedef struct packed {
    logic rdEn;   // issue one buffer read this cycle
    logic wrEn;   // commit the load-port write this cycle
  } gdiStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } gdiState_t;

endpackage

// File: rtl/gdi_ctrl.sv
module gdi_ctrl
  import gdi_pkg::*;
#(
  parameter int MAX_SC  = 96,
  parameter int MAX_SYM = 14,
  parameter int AW      = 11,
  parameter int SCW     = 7,
  parameter int SYMW    = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [SCW-1:0]  cfgNumSc,
  input  logic [SYMW-1:0] cfgNumSym,
  input  logic            wrEnIn,
  input  logic            canIssue,
  input  logic            emptyNext,
  output gdiStrobe_t      strobe,
  output logic [AW-1:0]   rdAddr,
  output logic            busy,
  output logic            done,
  output logic            cfgErr
);

  localparam logic [SCW-1:0]  SC_LIMIT  = SCW'(MAX_SC);
  localparam logic [SYMW-1:0] SYM_LIMIT = SYMW'(MAX_SYM);

  gdiState_t       state;
  logic [SCW-1:0]  numScR;
  logic [SYMW-1:0] numSymR;
  logic [1:0]      subOff;
  logic [SYMW-1:0] symIdx;
  logic [AW-1:0]   symBase;
  logic [SCW-1:0]  grpBase;
  logic            doneR;
  logic            errR;

  logic cfgBad;
  logic issue;
  logic lastSym;
  logic lastIssue;

  always_comb begin
    cfgBad = (cfgNumSc == '0) || (cfgNumSc[1:0] != 2'b00) || (cfgNumSc > SC_LIMIT) ||
             (cfgNumSym == '0) || (cfgNumSym > SYM_LIMIT);
    issue     = (state == ST_RUN) && canIssue;
    lastSym   = (symIdx == numSymR - SYMW'(1));
    lastIssue = (subOff == 2'd3) && lastSym && (grpBase == numScR - SCW'(4));
    rdAddr    = symBase + AW'(grpBase) + AW'(subOff);
    strobe.rdEn = issue;
    strobe.wrEn = wrEnIn && (state == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      numScR  <= '0;
      numSymR <= '0;
      subOff  <= '0;
      symIdx  <= '0;
      symBase <= '0;
      grpBase <= '0;
      doneR   <= 1'b0;
      errR    <= 1'b0;
    end else begin
      doneR <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            errR <= cfgBad;
            if (!cfgBad) begin
              numScR  <= cfgNumSc;
              numSymR <= cfgNumSym;
              subOff  <= '0;
              symIdx  <= '0;
              symBase <= '0;
              grpBase <= '0;
              state   <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (issue) begin
            if (subOff == 2'd3) begin
              subOff <= '0;
              if (lastSym) begin
                symIdx  <= '0;
                symBase <= '0;
                grpBase <= grpBase + SCW'(4);
              end else begin
                symIdx  <= symIdx + SYMW'(1);
                symBase <= symBase + AW'(numScR);
              end
            end else begin
              subOff <= subOff + 2'd1;
            end
            if (lastIssue) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (emptyNext) begin
            doneR <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign done   = doneR;
  assign cfgErr = errR;

endmodule

// File: rtl/gdi_datapath.sv
module gdi_datapath
  import gdi_pkg::*;
#(
  parameter int DW    = 16,
  parameter int AW    = 11,
  parameter int DEPTH = 1344
) (
  input  logic          clk,
  input  logic          rstN,
  input  gdiStrobe_t    strobe,
  input  logic [AW-1:0] rdAddr,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          outReady,
  output logic          canIssue,
  output logic          emptyNext,
  output logic          outValid,
  output logic [DW-1:0] outData
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ramQ;
  logic [AW-1:0] portAddr;

  logic [1:0]    occ;
  logic          pend;
  logic [DW-1:0] slot0;
  logic [DW-1:0] slot1;
  logic          pop;
  logic [1:0]    afterPop;
  logic [1:0]    nextOcc;

  // Single shared port: reads take priority; the sequencer only writes when idle
  assign portAddr = strobe.rdEn ? rdAddr : wrAddr;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[portAddr] <= wrData;
    ramQ <= mem[portAddr];
  end

  always_comb begin
    pop       = (occ != 2'd0) && outReady;
    afterPop  = occ - {1'b0, pop};
    nextOcc   = afterPop + {1'b0, pend};
    canIssue  = (nextOcc < 2'd2);
    emptyNext = (nextOcc == 2'd0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ   <= '0;
      pend  <= 1'b0;
      slot0 <= '0;
      slot1 <= '0;
    end else begin
      pend <= strobe.rdEn;
      occ  <= nextOcc;
      if (pop) begin
        if (occ == 2'd2)  slot0 <= slot1;
        else if (pend)    slot0 <= ramQ;
      end else if ((occ == 2'd0) && pend) begin
        slot0 <= ramQ;
      end
      if (pend && (afterPop == 2'd1)) slot1 <= ramQ;
    end
  end

  assign outValid = (occ != 2'd0);
  assign outData  = slot0;

endmodule

// File: rtl/grp4_deinterleaver.sv
module grp4_deinterleaver
  import gdi_pkg::*;
#(
  parameter int DW      = 16,
  parameter int MAX_SC  = 96,
  parameter int MAX_SYM = 14,
  localparam int DEPTH  = MAX_SC * MAX_SYM,
  localparam int AW     = $clog2(DEPTH),
  localparam int SCW    = $clog2(MAX_SC + 1),
  localparam int SYMW   = $clog2(MAX_SYM + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [AW-1:0]   wrAddr,
  input  logic [DW-1:0]   wrData,
  input  logic [SCW-1:0]  cfgNumSc,
  input  logic [SYMW-1:0] cfgNumSym,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic            cfgErr,
  output logic            outValid,
  input  logic            outReady,
  output logic [DW-1:0]   outData
);

  gdiStrobe_t    strobe;
  logic [AW-1:0] rdAddr;
  logic          canIssue;
  logic          emptyNext;

  gdi_ctrl #(
    .MAX_SC (MAX_SC),
    .MAX_SYM(MAX_SYM),
    .AW     (AW),
    .SCW    (SCW),
    .SYMW   (SYMW)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cfgNumSc (cfgNumSc),
    .cfgNumSym(cfgNumSym),
    .wrEnIn   (wrEn),
    .canIssue (canIssue),
    .emptyNext(emptyNext),
    .strobe   (strobe),
    .rdAddr   (rdAddr),
    .busy     (busy),
    .done     (done),
    .cfgErr   (cfgErr)
  );

  gdi_datapath #(
    .DW   (DW),
    .AW   (AW),
    .DEPTH(DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdAddr   (rdAddr),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .outReady (outReady),
    .canIssue (canIssue),
    .emptyNext(emptyNext),
    .outValid (outValid),
    .outData  (outData)
  );

endmodule

// File: rtl/gdi_checker.sv
module gdi_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          done,
  input logic          cfgErr,
  input logic          outValid,
  input logic          outReady,
  input logic [DW-1:0] outData
);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !outValid));

  assert_err_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (!busy && !outValid));

  assert_idle_silent_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !outValid);

endmodule

bind grp4_deinterleaver gdi_checker #(.DW(DW)) u_gdi_checker (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .cfgErr  (cfgErr),
  .outValid(outValid),
  .outReady(outReady),
  .outData (outData)
);

// File: tb/grp4_deinterleaver_bench.sv
module grp4_deinterleaver_bench;

  localparam int DW      = 16;
  localparam int MAX_SC  = 96;
  localparam int MAX_SYM = 14;
  localparam int DEPTH   = MAX_SC * MAX_SYM;
  localparam int AW      = $clog2(DEPTH);
  localparam int SCW     = $clog2(MAX_SC + 1);
  localparam int SYMW    = $clog2(MAX_SYM + 1);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            wrEn = 1'b0;
  logic [AW-1:0]   wrAddr = '0;
  logic [DW-1:0]   wrData = '0;
  logic [SCW-1:0]  cfgNumSc = '0;
  logic [SYMW-1:0] cfgNumSym = '0;
  logic            start = 1'b0;
  logic            busy, done, cfgErr, outValid;
  logic            outReady = 1'b0;
  logic [DW-1:0]   outData;

  always #4 clk = ~clk;

  grp4_deinterleaver u_grp4_deinterleaver (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfgNumSc(cfgNumSc), .cfgNumSym(cfgNumSym), .start(start),
    .busy(busy), .done(done), .cfgErr(cfgErr),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] expQ [$];
  int  readyMode = 0;
  int  cycle = 0;
  int  lastHs = 0;
  bit  haveLast = 0;
  bit  expectDone = 0;
  bit  doneSeen = 0;
  bit  prevStall = 0;
  logic [DW-1:0] prevData = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each handshake seen at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cycle++;
      if (rstN) begin
        if (prevStall) begin
          check(outValid == 1'b1, "R3 valid held", int'(outValid), 1);
          check(outData == prevData, "R3 data held", int'(outData), int'(prevData));
        end
        if (expectDone) begin
          check(done == 1'b1, "R5 done after last", int'(done), 1);
          check(busy == 1'b0, "R5 idle at done", int'(busy), 0);
          expectDone = 0;
          doneSeen = 1;
        end else if (done) begin
          check(1'b0, "R2 early or stray done", 1, 0);
        end
        case (readyMode)
          0: outReady = 1'b1;
          1: outReady = 1'($urandom_range(0, 1));
          default: outReady = cycle[0];
        endcase
        if (outValid && outReady) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R4 extra sample", int'(outData), 0);
          end else begin
            automatic logic [DW-1:0] e = expQ.pop_front();
            check(outData == e, "R1 R4 sample order", int'(outData), int'(e));
            if (readyMode == 0 && haveLast)
              check(cycle == lastHs + 1, "R10 gap-free", cycle, lastHs + 1);
            haveLast = 1;
            lastHs = cycle;
            if (expQ.size() == 0) expectDone = 1;
          end
        end
        prevStall = outValid && !outReady;
        prevData  = outData;
      end else begin
        outReady = 1'b0;
      end
    end
  end

  task automatic loadBuf(input int nSc, input int nSym);
    for (int a = 0; a < nSc * nSym; a++) begin
      @(negedge clk);
      model[a] = DW'($urandom);
      wrEn = 1'b1; wrAddr = AW'(a); wrData = model[a];
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runFrame(input int nSc, input int nSym, input int mode,
                          input bit doLoad, input bit disturb);
    if (doLoad) loadBuf(nSc, nSym);
    for (int g = 0; g < nSc / 4; g++)
      for (int i = 0; i < 4 * nSym; i++)
        expQ.push_back(model[(i / 4) * nSc + g * 4 + (i % 4)]);
    readyMode = mode;
    haveLast = 0;
    doneSeen = 0;
    @(negedge clk);
    cfgNumSc = SCW'(nSc); cfgNumSym = SYMW'(nSym); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    check(cfgErr == 1'b0, "R6 error cleared", int'(cfgErr), 0);
    if (disturb) begin
      repeat (3) @(negedge clk);
      // R7: second start with other counts; R8: write during run
      cfgNumSc = SCW'(4); cfgNumSym = SYMW'(1); start = 1'b1;
      wrEn = 1'b1; wrAddr = '0; wrData = ~model[0];
      @(negedge clk);
      start = 1'b0; wrEn = 1'b0;
      check(busy == 1'b1, "R7 still busy", int'(busy), 1);
    end
    while (!doneSeen) @(negedge clk);
    check(expQ.size() == 0, "R2 sample count", expQ.size(), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic badFrame(input int nSc, input int nSym);
    @(negedge clk);
    cfgNumSc = SCW'(nSc); cfgNumSym = SYMW'(nSym); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cfgErr == 1'b1, "R6 error flag", int'(cfgErr), 1);
    check(busy == 1'b0, "R6 stays idle", int'(busy), 0);
    repeat (10) @(negedge clk);
    check(outValid == 1'b0, "R6 no output", int'(outValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R9 reset valid", int'(outValid), 0);
    check(busy == 1'b0, "R9 reset busy", int'(busy), 0);
    check(done == 1'b0, "R9 reset done", int'(done), 0);
    check(cfgErr == 1'b0, "R9 reset error", int'(cfgErr), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    runFrame(8, 2, 0, 1, 0);
    runFrame(12, 14, 1, 1, 1);
    runFrame(12, 14, 0, 0, 0);
    badFrame(6, 2);
    runFrame(4, 1, 2, 1, 0);
    badFrame(0, 3);
    badFrame(8, 0);
    badFrame(100, 2);
    runFrame(96, 14, 1, 1, 0);
    runFrame(96, 3, 0, 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule